// File: doc/BRIEF.md
# Interrupt Pending Register with Delayed Peripheral Clears

This block holds the pending state of the vectored interrupts of a small processor core. Seven level-type request lines feed it. Two come from a command-driven buffered I/O unit and five come from a serial I/O unit. While a request line is high, it sets its pending bit on every cycle. A pending bit goes back to 0 in one of two ways: software writes a 1 to it, or the core takes that interrupt. The pending bit stays set while its request line is still high.

Each request line is raised by a one-cycle event pulse from its peripheral. Certain peripheral accesses lower a request line. These are buffer commands, reads and writes of the serial data registers, and writes of the serial control registers. The line does not fall at once. It falls after a fixed pipeline latency that depends on the source. While a line is still counting down, it keeps setting its pending bit. So a pending clear issued too early does not hold, and the interrupt is taken again. Each source has its own countdown counter that models this delay.

Source bit order in every vector: 0 buffered input full, 1 buffered output empty, 2 serial input full, 3 serial input framing error, 4 serial output empty, 5 serial output framing error, 6 serial collision. In the requirements below, "sampled at edge E" names the rising clock edge that captures an input. "Edge E+k" is the k-th edge after it.

Top module: `isr_status_unit`

## Requirements
- R1: While reset is asserted (rst_ni low), pend_o and req_o are all zero.
- R2: An event pulse on evt_i[i] sampled at edge E makes req_o[i] high after edge E. A request that is high before an edge makes pend_o[i] high after that edge. A pending bit never rises while its request line is low.
- R3: A status write sampled with sts_wdata_i[i]=1 clears pend_o[i] if req_o[i] is low before that edge. If the request is high, the set wins and the bit stays 1. Bits written with 0 keep their value.
- R4: A take strobe sampled with take_idx_i=i clears only pend_o[i], under the same set-wins rule. All other pending bits keep their value.
- R5: A command write whose bits 15:12 are 0x4 lowers request 0 at edge E+3. A status clear of bit 0 sampled at edge E+3 is overridden. One sampled at edge E+4 sticks.
- R6: A command write whose bits 15:12 are 0x6 raises request 1 after edge E. It lowers request 0 at edge E+5. A status clear of bit 0 is effective only from edge E+6.
- R7: A command write whose bits 15:12 are 0x5 changes no request line. A control-register write with the clear bits (bit 4 for input; bits 4 and 7 for output) all zero also changes no request line.
- R8: A read strobe of the serial input data register lowers request 2 at edge E+1. A status clear becomes effective from edge E+2.
- R9: A serial input control write with bit 4 set lowers requests 2 and 3 at edge E+3. A status clear becomes effective from edge E+4.
- R10: A serial output control write with bit 4 or bit 7 set lowers requests 4, 5 and 6 at edge E+1. A status clear becomes effective from edge E+2.
- R11: A write strobe of the serial output data register lowers request 4 at edge E+3. A status clear becomes effective from edge E+4.
- R12: A second clear action aimed at a request that is already counting down restarts its countdown from the new action. Two actions with different latencies on one source in the same cycle use the longer latency.
- R13: An event pulse sampled at the same edge at which the request would fall keeps the request high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | Per-source request raise pulses |
| cmd_we_i | input | 1 | Buffered unit command write strobe |
| cmd_wdata_i | input | 16 | Command word; bits 15:12 hold the opcode |
| sin_rd_i | input | 1 | Serial input data register read strobe |
| sin_ctl_we_i | input | 1 | Serial input control register write strobe |
| sin_ctl_wdata_i | input | 16 | Serial input control write data (bit 4 clears) |
| sout_ctl_we_i | input | 1 | Serial output control register write strobe |
| sout_ctl_wdata_i | input | 16 | Serial output control write data (bits 4, 7 clear) |
| sout_wr_i | input | 1 | Serial output data register write strobe |
| take_i | input | 1 | Core takes an interrupt |
| take_idx_i | input | 3 | Index of the interrupt being taken |
| sts_we_i | input | 1 | Pending-status write strobe |
| sts_wdata_i | input | 7 | Write-one-to-clear mask |
| pend_o | output | 7 | Pending bits |
| req_o | output | 7 | Current request levels |

## Verification
A stimulus driven after a falling edge is sampled at the next rising edge, E. A raised request therefore shows one cycle after the drive, and a pending bit that follows it shows one cycle later. A request cleared with latency L still reads high L-1 cycles after the drive and reads low at L cycles. For each delayed clear, the bench issues one status clear sampled one edge too early and one sampled exactly on time. It then expects the pending bit to stay 1 after the first and to read 0 after the second. Each expected value goes into the scoreboard tagged with the cycle count at which it is due. The monitor compares it on the falling edge of that exact cycle, never earlier or later.

// File: rtl/isr_status_pkg.sv
package isr_status_pkg;
   localparam int unsigned NSRC     = 7;
   localparam int unsigned SRC_BIF  = 0;
   localparam int unsigned SRC_BOE  = 1;
   localparam int unsigned SRC_SIF  = 2;
   localparam int unsigned SRC_SFE  = 3;
   localparam int unsigned SRC_SOE  = 4;
   localparam int unsigned SRC_SOFE = 5;
   localparam int unsigned SRC_SCOL = 6;

   typedef enum logic [3:0] {
      OP_IN_LEN  = 4'h4,
      OP_OUT_LEN = 4'h5,
      OP_RESET   = 4'h6
   } cmd_op_e;
endpackage

// File: rtl/isr_clr_decode.sv
module isr_clr_decode
   import isr_status_pkg::*;
#(
   parameter int unsigned CMD_W        = 16,
   parameter int unsigned CTL_W        = 16,
   parameter int unsigned CW           = 3,
   parameter int unsigned LAT_IN_LEN   = 4,
   parameter int unsigned LAT_RESET    = 6,
   parameter int unsigned LAT_SIN_RD   = 2,
   parameter int unsigned LAT_SIN_CTL  = 4,
   parameter int unsigned LAT_SOUT_CTL = 2,
   parameter int unsigned LAT_SOUT_WR  = 4,
   parameter int unsigned IN_CLR_BIT   = 4,
   parameter int unsigned OUT_CLR_BIT  = 4,
   parameter int unsigned COL_CLR_BIT  = 7
) (
   input  logic                      cmd_we_i,
   input  logic [CMD_W-1:0]          cmd_wdata_i,
   input  logic                      sin_rd_i,
   input  logic                      sin_ctl_we_i,
   input  logic [CTL_W-1:0]          sin_ctl_wdata_i,
   input  logic                      sout_ctl_we_i,
   input  logic [CTL_W-1:0]          sout_ctl_wdata_i,
   input  logic                      sout_wr_i,
   output logic [NSRC-1:0]           ld_o,
   output logic [NSRC-1:0][CW-1:0]   lat_o,
   output logic [NSRC-1:0]           raise_o
);
   localparam int unsigned OP_LSB = CMD_W - 4;
   localparam logic [CW-1:0] V_IN_LEN   = CW'(LAT_IN_LEN - 1);
   localparam logic [CW-1:0] V_RESET    = CW'(LAT_RESET - 1);
   localparam logic [CW-1:0] V_SIN_RD   = CW'(LAT_SIN_RD - 1);
   localparam logic [CW-1:0] V_SIN_CTL  = CW'(LAT_SIN_CTL - 1);
   localparam logic [CW-1:0] V_SOUT_CTL = CW'(LAT_SOUT_CTL - 1);
   localparam logic [CW-1:0] V_SOUT_WR  = CW'(LAT_SOUT_WR - 1);

   function automatic logic [CW-1:0] pick_max(input logic a_en, input logic [CW-1:0] a,
                                              input logic b_en, input logic [CW-1:0] b);
      logic [CW-1:0] x, y;
      x = a_en ? a : '0;
      y = b_en ? b : '0;
      return (x > y) ? x : y;
   endfunction

   logic [3:0] op;
   logic t_in_len, t_reset, t_srd, t_sctl, t_octl, t_owr;

   assign op       = cmd_wdata_i[OP_LSB +: 4];
   assign t_in_len = cmd_we_i && (op == OP_IN_LEN);
   assign t_reset  = cmd_we_i && (op == OP_RESET);
   assign t_srd    = sin_rd_i;
   assign t_sctl   = sin_ctl_we_i && sin_ctl_wdata_i[IN_CLR_BIT];
   assign t_octl   = sout_ctl_we_i &&
                     (sout_ctl_wdata_i[OUT_CLR_BIT] || sout_ctl_wdata_i[COL_CLR_BIT]);
   assign t_owr    = sout_wr_i;

   always_comb begin
      ld_o    = '0;
      lat_o   = '0;
      raise_o = '0;
      ld_o[SRC_BIF]     = t_in_len | t_reset;
      lat_o[SRC_BIF]    = pick_max(t_in_len, V_IN_LEN, t_reset, V_RESET);
      raise_o[SRC_BOE]  = t_reset;
      ld_o[SRC_SIF]     = t_srd | t_sctl;
      lat_o[SRC_SIF]    = pick_max(t_srd, V_SIN_RD, t_sctl, V_SIN_CTL);
      ld_o[SRC_SFE]     = t_sctl;
      lat_o[SRC_SFE]    = V_SIN_CTL;
      ld_o[SRC_SOE]     = t_octl | t_owr;
      lat_o[SRC_SOE]    = pick_max(t_octl, V_SOUT_CTL, t_owr, V_SOUT_WR);
      ld_o[SRC_SOFE]    = t_octl;
      lat_o[SRC_SOFE]   = V_SOUT_CTL;
      ld_o[SRC_SCOL]    = t_octl;
      lat_o[SRC_SCOL]   = V_SOUT_CTL;
   end
endmodule

// File: rtl/isr_req_line.sv
module isr_req_line #(
   parameter int unsigned CW = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          raise_i,
   input  logic          ld_i,
   input  logic [CW-1:0] lat_i,
   output logic          req_o
);
   logic [CW-1:0] cnt_q;
   logic          drop;

   assign drop = !ld_i && (cnt_q == CW'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         req_o <= 1'b0;
      end else begin
         if (ld_i)
            cnt_q <= lat_i;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
         if (raise_i)
            req_o <= 1'b1;
         else if (drop)
            req_o <= 1'b0;
      end
   end
endmodule

// File: rtl/isr_pend_reg.sv
module isr_pend_reg #(
   parameter int unsigned N = 7
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         pend_o <= '0;
      else
         pend_o <= (pend_o & ~clr_i) | req_i;
   end
endmodule

// File: rtl/isr_status_unit.sv
module isr_status_unit
   import isr_status_pkg::*;
#(
   parameter int unsigned CMD_W        = 16,
   parameter int unsigned CTL_W        = 16,
   parameter int unsigned LAT_IN_LEN   = 4,
   parameter int unsigned LAT_RESET    = 6,
   parameter int unsigned LAT_SIN_RD   = 2,
   parameter int unsigned LAT_SIN_CTL  = 4,
   parameter int unsigned LAT_SOUT_CTL = 2,
   parameter int unsigned LAT_SOUT_WR  = 4,
   parameter int unsigned IDX_W        = $clog2(NSRC)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NSRC-1:0]  evt_i,
   input  logic             cmd_we_i,
   input  logic [CMD_W-1:0] cmd_wdata_i,
   input  logic             sin_rd_i,
   input  logic             sin_ctl_we_i,
   input  logic [CTL_W-1:0] sin_ctl_wdata_i,
   input  logic             sout_ctl_we_i,
   input  logic [CTL_W-1:0] sout_ctl_wdata_i,
   input  logic             sout_wr_i,
   input  logic             take_i,
   input  logic [IDX_W-1:0] take_idx_i,
   input  logic             sts_we_i,
   input  logic [NSRC-1:0]  sts_wdata_i,
   output logic [NSRC-1:0]  pend_o,
   output logic [NSRC-1:0]  req_o
);
   localparam int unsigned LAT_MAX_A = (LAT_IN_LEN > LAT_RESET) ? LAT_IN_LEN : LAT_RESET;
   localparam int unsigned LAT_MAX_B = (LAT_SIN_RD > LAT_SIN_CTL) ? LAT_SIN_RD : LAT_SIN_CTL;
   localparam int unsigned LAT_MAX_C = (LAT_SOUT_CTL > LAT_SOUT_WR) ? LAT_SOUT_CTL : LAT_SOUT_WR;
   localparam int unsigned LAT_MAX_D = (LAT_MAX_A > LAT_MAX_B) ? LAT_MAX_A : LAT_MAX_B;
   localparam int unsigned LAT_MAX   = (LAT_MAX_C > LAT_MAX_D) ? LAT_MAX_C : LAT_MAX_D;
   localparam int unsigned CW        = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1;

   if (CMD_W < 16) begin : g_bad_cmd_w
      $error("isr_status_unit: CMD_W must be at least 16");
   end
   if (CTL_W < 8) begin : g_bad_ctl_w
      $error("isr_status_unit: CTL_W must be at least 8");
   end
   if (LAT_IN_LEN < 2 || LAT_RESET < 2 || LAT_SIN_RD < 2 ||
       LAT_SIN_CTL < 2 || LAT_SOUT_CTL < 2 || LAT_SOUT_WR < 2) begin : g_bad_lat
      $error("isr_status_unit: every clear latency must be at least 2");
   end
   if ((1 << IDX_W) < NSRC) begin : g_bad_idx_w
      $error("isr_status_unit: IDX_W too narrow for the source count");
   end

   logic [NSRC-1:0]         ld;
   logic [NSRC-1:0][CW-1:0] lat;
   logic [NSRC-1:0]         raise_x;
   logic [NSRC-1:0]         take_mask;
   logic [NSRC-1:0]         clr;

   isr_clr_decode #(
      .CMD_W(CMD_W), .CTL_W(CTL_W), .CW(CW),
      .LAT_IN_LEN(LAT_IN_LEN), .LAT_RESET(LAT_RESET),
      .LAT_SIN_RD(LAT_SIN_RD), .LAT_SIN_CTL(LAT_SIN_CTL),
      .LAT_SOUT_CTL(LAT_SOUT_CTL), .LAT_SOUT_WR(LAT_SOUT_WR),
      .IN_CLR_BIT(4), .OUT_CLR_BIT(4), .COL_CLR_BIT(7)
   ) u_decode (
      .cmd_we_i        (cmd_we_i),
      .cmd_wdata_i     (cmd_wdata_i),
      .sin_rd_i        (sin_rd_i),
      .sin_ctl_we_i    (sin_ctl_we_i),
      .sin_ctl_wdata_i (sin_ctl_wdata_i),
      .sout_ctl_we_i   (sout_ctl_we_i),
      .sout_ctl_wdata_i(sout_ctl_wdata_i),
      .sout_wr_i       (sout_wr_i),
      .ld_o            (ld),
      .lat_o           (lat),
      .raise_o         (raise_x)
   );

   for (genvar s = 0; s < NSRC; s++) begin : g_line
      isr_req_line #(.CW(CW)) u_line (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .raise_i(evt_i[s] | raise_x[s]),
         .ld_i   (ld[s]),
         .lat_i  (lat[s]),
         .req_o  (req_o[s])
      );
      assign take_mask[s] = take_i && (take_idx_i == IDX_W'(s));
   end

   assign clr = (sts_we_i ? sts_wdata_i : '0) | take_mask;

   isr_pend_reg #(.N(NSRC)) u_pend (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req_o),
      .clr_i (clr),
      .pend_o(pend_o)
   );
endmodule

// File: rtl/isr_status_chk.sv
module isr_status_chk
   import isr_status_pkg::*;
#(
   parameter int unsigned IDX_W = 3
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [NSRC-1:0]  evt_i,
   input logic             take_i,
   input logic [IDX_W-1:0] take_idx_i,
   input logic             sts_we_i,
   input logic [NSRC-1:0]  sts_wdata_i,
   input logic [NSRC-1:0]  pend_o,
   input logic [NSRC-1:0]  req_o
);
   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      AST_EVT_RAISES_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
         evt_i[i] |=> req_o[i]); // R2
      AST_REQ_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
         req_o[i] |=> pend_o[i]); // R2
      AST_NO_SPURIOUS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!pend_o[i] && !req_o[i]) |=> !pend_o[i]); // R2
      AST_SW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sts_we_i && sts_wdata_i[i] && !req_o[i]) |=> !pend_o[i]); // R3
      AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (pend_o[i] && !(sts_we_i && sts_wdata_i[i]) &&
          !(take_i && take_idx_i == IDX_W'(i))) |=> pend_o[i]); // R3
      AST_TAKE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (take_i && take_idx_i == IDX_W'(i) && !req_o[i] && !sts_we_i) |=> !pend_o[i]); // R4
   end
endmodule

bind isr_status_unit isr_status_chk #(.IDX_W(IDX_W)) u_isr_status_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .evt_i      (evt_i),
   .take_i     (take_i),
   .take_idx_i (take_idx_i),
   .sts_we_i   (sts_we_i),
   .sts_wdata_i(sts_wdata_i),
   .pend_o     (pend_o),
   .req_o      (req_o)
);

// File: tb/test_isr_status_unit.sv
module test_isr_status_unit;
   localparam int N = 7;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic [N-1:0] evt = '0;
   logic        cmd_we = 1'b0;
   logic [15:0] cmd_wdata = '0;
   logic        sin_rd = 1'b0;
   logic        sin_ctl_we = 1'b0;
   logic [15:0] sin_ctl_wdata = '0;
   logic        sout_ctl_we = 1'b0;
   logic [15:0] sout_ctl_wdata = '0;
   logic        sout_wr = 1'b0;
   logic        take = 1'b0;
   logic [2:0]  take_idx = '0;
   logic        sts_we = 1'b0;
   logic [N-1:0] sts_wdata = '0;
   logic [N-1:0] pend, req;

   always #10 clk = ~clk; // 50 MHz

   isr_status_unit i_isr_status_unit (
      .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt),
      .cmd_we_i(cmd_we), .cmd_wdata_i(cmd_wdata),
      .sin_rd_i(sin_rd), .sin_ctl_we_i(sin_ctl_we), .sin_ctl_wdata_i(sin_ctl_wdata),
      .sout_ctl_we_i(sout_ctl_we), .sout_ctl_wdata_i(sout_ctl_wdata),
      .sout_wr_i(sout_wr), .take_i(take), .take_idx_i(take_idx),
      .sts_we_i(sts_we), .sts_wdata_i(sts_wdata),
      .pend_o(pend), .req_o(req));

   typedef struct {
      int          due;
      logic [N-1:0] rmask, rexp, pmask, pexp;
      string       tag;
   } item_t;

   item_t sb[$];
   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;
   bit reported = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare each expected item on the falling edge of its due cycle
   always @(negedge clk) begin
      for (int k = sb.size() - 1; k >= 0; k--) begin
         if (sb[k].due == cyc) begin
            n_cmp++;
            if (((req & sb[k].rmask) != (sb[k].rexp & sb[k].rmask)) ||
                ((pend & sb[k].pmask) != (sb[k].pexp & sb[k].pmask))) begin
               n_bad++;
               $display("FAIL %s cyc=%0d req=%b exp %b (mask %b) pend=%b exp %b (mask %b)",
                        sb[k].tag, cyc, req, sb[k].rexp, sb[k].rmask,
                        pend, sb[k].pexp, sb[k].pmask);
            end
            sb.delete(k);
         end
      end
   end

   task automatic push(input int dly, input logic [N-1:0] rmask, input logic [N-1:0] rexp,
                       input logic [N-1:0] pmask, input logic [N-1:0] pexp, input string tag);
      item_t it;
      it.due = cyc + dly; it.rmask = rmask; it.rexp = rexp;
      it.pmask = pmask; it.pexp = pexp; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle();
      evt = '0; cmd_we = 0; sin_rd = 0; sin_ctl_we = 0; sout_ctl_we = 0;
      sout_wr = 0; take = 0; sts_we = 0; sts_wdata = '0;
   endtask

   task automatic apply(input int kind);
      case (kind)
         0: begin cmd_we = 1; cmd_wdata = 16'h4000; end
         1: begin cmd_we = 1; cmd_wdata = 16'h6000; end
         2: sin_rd = 1;
         3: begin sin_ctl_we = 1; sin_ctl_wdata = 16'h0010; end
         4: begin sout_ctl_we = 1; sout_ctl_wdata = 16'h0010; end
         5: begin sout_ctl_we = 1; sout_ctl_wdata = 16'h0080; end
         default: sout_wr = 1;
      endcase
   endtask

   // raise a source, fire a clear action, then probe the early and the on-time status clear
   task automatic probe(input int src, input int lat, input int kind, input string tag);
      logic [N-1:0] m;
      int base;
      m = N'(1) << src;
      idle(); evt = m; tick(); idle(); tick();
      base = cyc;
      apply(kind);
      push(lat - 1, m, m, '0, '0, {tag, " request still high"});
      push(lat, m, '0, '0, '0, {tag, " request dropped"});
      if (kind == 1) push(1, 7'b0000010, 7'b0000010, '0, '0, "R6 reset raises output-empty");
      tick(); idle();
      while (cyc < base + lat - 1) tick();
      sts_we = 1; sts_wdata = m;
      push(1, '0, '0, m, m, {tag, " early status clear overridden"});
      tick();
      sts_we = 1; sts_wdata = m;
      push(1, '0, '0, m, '0, {tag, " on-time status clear"});
      tick(); idle(); tick();
   endtask

   initial begin
      int base;
      repeat (3) tick();
      n_cmp++;
      if (pend !== '0 || req !== '0) begin
         n_bad++;
         $display("FAIL R1 reset state pend=%b req=%b exp 0 0", pend, req);
      end
      rst_ni = 1;
      tick();

      // R2: raise and pending follow
      evt = 7'b0000001;
      push(1, 7'b0000001, 7'b0000001, 7'b0000001, 7'b0000000, "R2 request up, pending not yet");
      push(2, '0, '0, 7'b0000001, 7'b0000001, "R2 pending set");
      tick(); idle(); tick(); tick();

      probe(0, 4, 0, "R5");
      probe(0, 6, 1, "R6");
      probe(2, 2, 2, "R8");
      probe(3, 4, 3, "R9");
      probe(4, 2, 4, "R10 bit4");
      probe(6, 2, 5, "R10 bit7");
      probe(5, 2, 4, "R10 framing");
      probe(4, 4, 6, "R11");

      // R7: length-update command and control writes without clear bits
      evt = 7'b0010111; tick(); idle();
      cmd_we = 1; cmd_wdata = 16'h5000; tick(); idle();
      sin_ctl_we = 1; sin_ctl_wdata = 16'h00EF;
      sout_ctl_we = 1; sout_ctl_wdata = 16'hFF6F;
      push(8, 7'b0010111, 7'b0010111, '0, '0, "R7 no request dropped");
      tick(); idle();
      repeat (9) tick();

      // R12: restart on repeated action
      evt = 7'b0000100; tick(); idle();
      base = cyc;
      sin_rd = 1;
      push(2, 7'b0000100, 7'b0000100, '0, '0, "R12 restarted countdown keeps request");
      push(3, 7'b0000100, 7'b0000000, '0, '0, "R12 restarted countdown drops");
      tick(); sin_rd = 1; tick(); idle();
      repeat (4) tick();

      // R12: two latencies on one source at once
      evt = 7'b0010000; tick(); idle();
      sout_ctl_we = 1; sout_ctl_wdata = 16'h0010; sout_wr = 1;
      push(3, 7'b0010000, 7'b0010000, '0, '0, "R12 longer latency still high");
      push(4, 7'b0010000, 7'b0000000, '0, '0, "R12 longer latency drop");
      tick(); idle();
      repeat (5) tick();

      // R13: raise coincides with drop
      evt = 7'b0000100; tick(); idle();
      sin_rd = 1; tick(); idle();
      evt = 7'b0000100;
      push(1, 7'b0000100, 7'b0000100, '0, '0, "R13 raise beats drop");
      push(4, 7'b0000100, 7'b0000100, '0, '0, "R13 request stays high");
      tick(); idle();
      repeat (5) tick();

      // R4 / R3: take clears only its bit, zero writes keep, one writes clear
      evt = 7'b0001100; tick(); idle();
      sin_ctl_we = 1; sin_ctl_wdata = 16'h0010; tick(); idle();
      repeat (5) tick();
      take = 1; take_idx = 3'd2;
      push(1, '0, '0, 7'b0001100, 7'b0001000, "R4 take clears only its bit");
      tick(); idle();
      sts_we = 1; sts_wdata = 7'b0000000;
      push(1, '0, '0, 7'b0001000, 7'b0001000, "R3 zero write keeps bit");
      tick(); idle();
      sts_we = 1; sts_wdata = 7'b0001000;
      push(1, '0, '0, 7'b0001000, 7'b0000000, "R3 one write clears bit");
      tick(); idle();
      evt = 7'b0100000; tick(); idle();
      sts_we = 1; sts_wdata = 7'b0100000;
      push(1, '0, '0, 7'b0100000, 7'b0100000, "R3 set wins over clear");
      tick(); idle();
      take = 1; take_idx = 3'd5;
      push(1, '0, '0, 7'b0100000, 7'b0100000, "R4 take overridden by live request");
      tick(); idle();
      repeat (4) tick();

      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard left %0d items unchecked", sb.size());
      end
      if (!reported) begin
         reported = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!reported) begin
         reported = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule